// File: doc/BRIEF.md
# Coprocessor Operand Transfer Sequencer

This block moves data operands between system memory and a numeric coprocessor whenever the coprocessor raises a transfer request. Each operand takes exactly two bus operations, and the first one is always a read. When data flows toward the coprocessor, the block first reads memory at the operand address and then writes the word to the coprocessor's fixed I/O data port at 0x0000FA. When data flows the other way, it first reads that port and then writes the word to memory at the operand address.

The block latches the address and the direction when it accepts a request. It raises an acknowledge during the first operation only. A bus cycle unit carries out each command and reports completion with a one-cycle done pulse, after as many wait cycles as it needs. The word fetched by the first operation is held in a register and is driven as the write data of the second operation.

The request is sampled when the second operation completes. If it is still active at that point, a further operand transfer begins at once, two bytes above the previous address. Because of this, every added wait cycle lengthens the window in which the coprocessor may withdraw its request.

Top module: `opx_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `xfer_ack`, `cmd_valid`, `cmd_write` and `cmd_mem` are 0 and `hold_data` is 0.
- R2: A high `xfer_req` sampled while idle issues the first operation on the next cycle: `cmd_valid`=1 and `cmd_write`=0.
- R3: With `to_cop`=1 at capture, the first operation is a memory read (`cmd_mem`=1, `cmd_write`=0) at the captured address. The second is an I/O write (`cmd_mem`=0, `cmd_write`=1) to address 0x0000FA.
- R4: With `to_cop`=0 at capture, the first operation is an I/O read from 0x0000FA. The second is a memory write at the captured address.
- R5: The `bus_rdata` value present when the first operation completes appears on `hold_data` and `cmd_wdata` from the second operation onward. It is unchanged through the second operation whatever `bus_rdata` does.
- R6: `xfer_ack` is 1 exactly while a first operation is outstanding and 0 during second operations.
- R7: While `bus_done` is low, the outstanding command (`cmd_valid`, `cmd_mem`, `cmd_write`, `cmd_addr`) does not change, for any number of wait cycles.
- R8: If `xfer_req` is high when the second operation completes, the next cycle starts a new first operation with the same direction at the previous operand address plus 2, modulo 2^24. If `xfer_req` is low, `cmd_valid` is 0 on the next cycle.
- R9: Changes on `opnd_addr` and `to_cop` after capture have no effect on the running sequence.
- R10: A `bus_done` pulse while idle with no request leaves `cmd_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_req | input | 1 | Operand transfer request from the coprocessor |
| to_cop | input | 1 | 1: memory to coprocessor, 0: coprocessor to memory |
| opnd_addr | input | 24 | Operand memory byte address |
| bus_done | input | 1 | One-cycle completion of the outstanding command |
| bus_rdata | input | 16 | Read data, valid with `bus_done` on a read |
| xfer_ack | output | 1 | Acknowledge, high during the first operation |
| cmd_valid | output | 1 | A command is outstanding |
| cmd_mem | output | 1 | 1: memory space, 0: I/O space |
| cmd_write | output | 1 | 1: write, 0: read |
| cmd_addr | output | 24 | Command address |
| cmd_wdata | output | 16 | Write data for the second operation |
| hold_data | output | 16 | Operand holding register |

## Verification
The assertions assume that `bus_done` is a single-cycle pulse, that it arrives only while a command is outstanding or during idle, and that it never comes in the same cycle that a command is first presented. They also assume that `bus_rdata` is meaningful only in the cycle of a read completion. The stimulus models the bus unit as a driver that waits a random 0 to 5 cycles after each command appears and then pulses done once. It scrambles `bus_rdata`, `opnd_addr` and `to_cop` at every other moment. It drops the request before the final completion of a sequence and keeps it high otherwise, so the request never changes in the cycle where it is sampled.

// File: rtl/opx_pkg.sv
package opx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } opx_state_e;
endpackage

// File: rtl/opx_step_fsm.sv
module opx_step_fsm
  import opx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic dir_in,
  input  logic done,
  output logic capture,
  output logic advance,
  output logic latch,
  output logic ack,
  output logic cmd_valid,
  output logic cmd_mem,
  output logic cmd_write
);
  opx_state_e state_q, state_n;
  logic dir_q, dir_n;

  always_comb begin
    state_n = state_q;
    capture = 1'b0;
    advance = 1'b0;
    latch   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req) begin
        state_n = ST_FIRST;
        capture = 1'b1;
      end
      ST_FIRST: if (done) begin
        state_n = ST_SECOND;
        latch   = 1'b1;
      end
      ST_SECOND: if (done) begin
        if (req) begin
          state_n = ST_FIRST;
          advance = 1'b1;
        end else begin
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
    dir_n = capture ? dir_in : dir_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      dir_q     <= 1'b0;
      ack       <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_mem   <= 1'b0;
      cmd_write <= 1'b0;
    end else begin
      state_q   <= state_n;
      dir_q     <= dir_n;
      ack       <= (state_n == ST_FIRST);
      cmd_valid <= (state_n != ST_IDLE);
      cmd_write <= (state_n == ST_SECOND);
      cmd_mem   <= (state_n == ST_FIRST)  ? dir_n :
                   (state_n == ST_SECOND) ? ~dir_n : 1'b0;
    end
  end

  assert_ack_first_R6: assert property (@(posedge clk) disable iff (rst)
    ack |-> (cmd_valid && !cmd_write));
  assert_hold_cmd_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !done) |=> (cmd_valid && $stable(cmd_write) && $stable(cmd_mem)));
  assert_space_swap_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_write && done) |=> (cmd_valid && cmd_write && (cmd_mem != $past(cmd_mem))));
  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid && req) |=> (cmd_valid && ack));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid && !req) |=> !cmd_valid);
endmodule

// File: rtl/opx_addr_gen.sv
module opx_addr_gen #(
  parameter int AW   = 24,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic          advance,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] cur_addr
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  always_ff @(posedge clk) begin
    if (rst)          cur_addr <= '0;
    else if (capture) cur_addr <= addr_in;
    else if (advance) cur_addr <= cur_addr + STEP_V;
  end
endmodule

// File: rtl/opx_hold_reg.sv
module opx_hold_reg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/opx_seq.sv
module opx_seq #(
  parameter int          AW        = 24,
  parameter int          DW        = 16,
  parameter int          STEP      = 2,
  parameter logic [AW-1:0] PORT_ADDR = 24'h0000FA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer_req,
  input  logic          to_cop,
  input  logic [AW-1:0] opnd_addr,
  input  logic          bus_done,
  input  logic [DW-1:0] bus_rdata,
  output logic          xfer_ack,
  output logic          cmd_valid,
  output logic          cmd_mem,
  output logic          cmd_write,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_wdata,
  output logic [DW-1:0] hold_data
);
  logic          capture, advance, latch;
  logic [AW-1:0] cur_addr;

  opx_step_fsm u_fsm (
    .clk(clk), .rst(rst), .req(xfer_req), .dir_in(to_cop), .done(bus_done),
    .capture(capture), .advance(advance), .latch(latch),
    .ack(xfer_ack), .cmd_valid(cmd_valid), .cmd_mem(cmd_mem), .cmd_write(cmd_write)
  );

  opx_addr_gen #(.AW(AW), .STEP(STEP)) u_addr (
    .clk(clk), .rst(rst), .capture(capture), .advance(advance),
    .addr_in(opnd_addr), .cur_addr(cur_addr)
  );

  opx_hold_reg #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .load(latch), .din(bus_rdata), .dout(hold_data)
  );

  assign cmd_addr  = cmd_mem ? cur_addr : PORT_ADDR;
  assign cmd_wdata = hold_data;

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_write && $past(cmd_valid && cmd_write)) |-> $stable(hold_data));
  assert_repeat_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_write && bus_done && xfer_req) |=> (xfer_ack && (cmd_mem != $past(cmd_mem))));
  assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_mem && $past(cmd_valid && cmd_mem)) |-> $stable(cmd_addr));
  assert_io_port_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_mem) |-> (cmd_addr == PORT_ADDR));
endmodule

// File: tb/tb_opx_seq.sv
module tb_opx_seq;
  localparam logic [23:0] PORT = 24'h0000FA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xfer_req = 1'b0, to_cop = 1'b0, bus_done = 1'b0;
  logic [23:0] opnd_addr = '0;
  logic [15:0] bus_rdata = '0;
  logic xfer_ack, cmd_valid, cmd_mem, cmd_write;
  logic [23:0] cmd_addr;
  logic [15:0] cmd_wdata, hold_data;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  opx_seq dut (
    .clk(clk), .rst(rst), .xfer_req(xfer_req), .to_cop(to_cop), .opnd_addr(opnd_addr),
    .bus_done(bus_done), .bus_rdata(bus_rdata), .xfer_ack(xfer_ack), .cmd_valid(cmd_valid),
    .cmd_mem(cmd_mem), .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .hold_data(hold_data)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [23:0] first_addr(input bit dir, input logic [23:0] a);
    return dir ? a : PORT;
  endfunction

  function automatic logic [23:0] second_addr(input bit dir, input logic [23:0] a);
    return dir ? PORT : a;
  endfunction

  function automatic logic [23:0] next_addr(input logic [23:0] a);
    return a + 24'd2;
  endfunction

  task automatic run_seq(input bit dir, input logic [23:0] a0, input int nw, input int wmax);
    logic [23:0] ea;
    logic [15:0] d;
    int w;
    ea = a0;
    xfer_req = 1'b1; to_cop = dir; opnd_addr = a0;
    @(negedge clk);
    for (int k = 0; k < nw; k++) begin
      chk(k == 0 ? "R2" : "R8", "first valid", {31'd0, cmd_valid}, 32'd1);
      chk("R6", "ack in first", {31'd0, xfer_ack}, 32'd1);
      chk(dir ? "R3" : "R4", "first space", {31'd0, cmd_mem}, {31'd0, dir});
      chk(dir ? "R3" : "R4", "first is read", {31'd0, cmd_write}, 32'd0);
      chk(k == 0 ? "R3" : "R8", "first addr", {8'd0, cmd_addr}, {8'd0, first_addr(dir, ea)});
      opnd_addr = 24'($urandom); to_cop = ~dir;
      w = $urandom_range(0, wmax);
      for (int i = 0; i < w; i++) begin
        @(negedge clk);
        chk("R7", "first held", {cmd_valid, cmd_write, cmd_addr}, {1'b1, 1'b0, first_addr(dir, ea)});
      end
      d = 16'($urandom);
      bus_rdata = d; bus_done = 1'b1;
      @(negedge clk);
      bus_done = 1'b0; bus_rdata = 16'($urandom);
      chk("R6", "ack low in second", {31'd0, xfer_ack}, 32'd0);
      chk(dir ? "R3" : "R4", "second op", {cmd_valid, cmd_write, cmd_mem}, {1'b1, 1'b1, ~dir});
      chk("R9", "second addr", {8'd0, cmd_addr}, {8'd0, second_addr(dir, ea)});
      chk("R5", "write data", {16'd0, cmd_wdata}, {16'd0, d});
      w = $urandom_range(0, wmax);
      for (int i = 0; i < w; i++) begin
        @(negedge clk);
        bus_rdata = 16'($urandom);
        chk("R5", "hold stable", {16'd0, hold_data}, {16'd0, d});
        chk("R7", "second held", {cmd_valid, cmd_write, cmd_addr}, {1'b1, 1'b1, second_addr(dir, ea)});
      end
      if (k == nw - 1) xfer_req = 1'b0;
      bus_done = 1'b1;
      @(negedge clk);
      bus_done = 1'b0;
      if (k == nw - 1) begin
        chk("R8", "idle after last", {30'd0, cmd_valid, xfer_ack}, 32'd0);
      end else begin
        ea = next_addr(ea);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", "outputs in reset", {28'd0, xfer_ack, cmd_valid, cmd_write, cmd_mem}, 32'd0);
    chk("R1", "hold in reset", {16'd0, hold_data}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "outputs after reset", {28'd0, xfer_ack, cmd_valid, cmd_write, cmd_mem}, 32'd0);
    bus_done = 1'b1;
    @(negedge clk);
    bus_done = 1'b0;
    chk("R10", "done while idle", {31'd0, cmd_valid}, 32'd0);
    @(negedge clk);
    chk("R10", "still idle", {31'd0, cmd_valid}, 32'd0);

    run_seq(1'b1, 24'h001000, 1, 0);
    run_seq(1'b0, 24'h123456, 1, 0);
    run_seq(1'b1, 24'hFFFFFE, 3, 3);
    run_seq(1'b0, 24'hFFFFFC, 3, 2);
    run_seq(1'b0, 24'h000000, 2, 5);

    for (int n = 0; n < 40; n++) begin
      run_seq(1'($urandom), 24'($urandom) & 24'hFFFFFE, $urandom_range(1, 4), 5);
      if ($urandom_range(0, 1) == 1) begin
        repeat ($urandom_range(1, 3)) @(negedge clk);
        chk("R8", "idle gap", {31'd0, cmd_valid}, 32'd0);
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule